// File: doc/BRIEF.md
# Mixed-Depth Pixel Source Selector

This block sits in a framebuffer pixel path where indexed colour and direct colour may share one screen. For every pixel it takes three words fetched upstream: an 8-bit colour index, a 32-bit direct-colour word and a 32-bit per-pixel control word. The control word decides which source the pixel uses. The block then produces one 32-bit output pixel. A mode input chooses RGB or BGR byte order for that output.

When the control word selects indexed colour, the block sends a read request to an external 256-entry colour table. It receives the 24-bit answer one cycle later. When the control word selects direct colour, the block unpacks the direct word itself. The direct word stores blue, green and red from the high byte down, with an unused top byte. Both sources go through one register stage, so pixels leave in the order they arrived.

The input is a valid/ready stream and so is the output. Backpressure stalls the stage without losing or repeating pixels. A palette answer that arrives while the output is stalled is kept until the output accepts the pixel.

Top module: `pix_mix_sel`

## Requirements
- R1: A pixel takes the direct path exactly when control bits 31:24 equal 8'h03. The other 24 control bits are ignored, and such a pixel raises no palette read.
- R2: Every other control top-byte value selects the palette path. On the acceptance cycle, `pal_rd_en` is high and `pal_rd_addr` equals `in_index`. `pal_rd_en` is never high in a cycle where no pixel is accepted.
- R3: On the direct path, red is direct bits 7:0, green is bits 15:8 and blue is bits 23:16. Bits 31:24 have no effect on the output.
- R4: The palette answer `pal_rd_data` is valid in the cycle after the read request. Its layout is red in 23:16, green in 15:8 and blue in 7:0.
- R5: The output pixel is {8'h00,R,G,B} when the pixel's mode bit is 0 and {8'h00,B,G,R} when it is 1. The mode bit is sampled together with the pixel on acceptance.
- R6: A pixel accepted at a clock edge appears on `out_valid`/`out_pixel` right after that edge. Pixels leave in arrival order.
- R7: While `out_valid` is high and `out_ready` is low, `out_pixel` holds steady. This includes palette pixels whose answer has already passed. `in_ready` is high exactly when the stage is empty or its pixel is being taken. No pixel is dropped or duplicated.
- R8: After reset, `out_valid` and `pal_rd_en` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Stage can take a pixel |
| in_index | input | 8 | Colour-table index |
| in_direct | input | 32 | Direct colour word (unused, B, G, R) |
| in_ctrl | input | 32 | Per-pixel control word; top byte selects source |
| in_bgr | input | 1 | Output byte order for this pixel: 0 RGB, 1 BGR |
| pal_rd_en | output | 1 | Colour-table read request |
| pal_rd_addr | output | 8 | Colour-table read address |
| pal_rd_data | input | 24 | Colour-table answer {R,G,B}, one cycle after request |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pixel | output | 32 | Packed output pixel |

## Verification
The assertions assume that the colour table answers exactly one cycle after each request. They also assume that a pixel's input fields stay meaningful only in its acceptance cycle. The bench models the table as a one-cycle register fed from `pal_rd_addr`. Between answers it drives a junk value on `pal_rd_data`, so any late read of the table shows up as a wrong colour. It changes inputs and `out_ready` only between clock edges, and it never withdraws a pixel it has offered. It mixes control codes around 8'h03 and nonzero direct top bytes with both byte orders. It runs under three output-stall patterns.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int unsigned CH_W = 8;
  localparam logic [7:0] DIRECT_TAG = 8'h03;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  function automatic logic is_direct(input logic [31:0] ctrl);
    return ctrl[31:24] == DIRECT_TAG;
  endfunction

  // Direct word: [31:24] unused, [23:16] blue, [15:8] green, [7:0] red
  function automatic rgb_t unpack_direct(input logic [31:0] w);
    rgb_t c;
    c.r = w[7:0];
    c.g = w[15:8];
    c.b = w[23:16];
    return c;
  endfunction

  // Colour-table answer: {R,G,B}
  function automatic rgb_t unpack_pal(input logic [3*CH_W-1:0] d);
    rgb_t c;
    c.r = d[23:16];
    c.g = d[15:8];
    c.b = d[7:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_pixel(input rgb_t c, input logic bgr);
    return bgr ? {8'h00, c.b, c.g, c.r} : {8'h00, c.r, c.g, c.b};
  endfunction
endpackage

// File: rtl/pms_decode.sv
module pms_decode
  import pms_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             take,
  input  logic [IDX_W-1:0] index,
  input  logic [31:0]      direct,
  input  logic [31:0]      ctrl,
  output logic             use_direct,
  output rgb_t             direct_rgb,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr
);
  always_comb begin
    use_direct = is_direct(ctrl);
    direct_rgb = unpack_direct(direct);
    rd_en      = take && !use_direct;
    rd_addr    = index;
  end
endmodule

// File: rtl/pms_stage.sv
module pms_stage
  import pms_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             pop,
  input  logic             use_direct,
  input  rgb_t             direct_rgb,
  input  logic             bgr_in,
  input  logic [3*CH_W-1:0] pal_data,
  output logic             st_valid,
  output logic             st_fresh,
  output logic             st_bgr,
  output rgb_t             st_rgb
);
  rgb_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_fresh <= 1'b0;
      st_bgr   <= 1'b0;
      held     <= '0;
    end else if (load) begin
      st_valid <= 1'b1;
      st_fresh <= !use_direct;
      st_bgr   <= bgr_in;
      if (use_direct) held <= direct_rgb;
    end else if (pop) begin
      st_valid <= 1'b0;
      st_fresh <= 1'b0;
    end else if (st_fresh) begin
      held     <= unpack_pal(pal_data);
      st_fresh <= 1'b0;
    end
  end

  always_comb st_rgb = st_fresh ? unpack_pal(pal_data) : held;
endmodule

// File: rtl/pms_pack.sv
module pms_pack
  import pms_pkg::*;
(
  input  rgb_t        rgb,
  input  logic        bgr,
  output logic [31:0] pixel
);
  always_comb pixel = pack_pixel(rgb, bgr);
endmodule

// File: rtl/pix_mix_sel.sv
module pix_mix_sel
  import pms_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  input  logic [31:0]      in_direct,
  input  logic [31:0]      in_ctrl,
  input  logic             in_bgr,
  output logic             pal_rd_en,
  output logic [IDX_W-1:0] pal_rd_addr,
  input  logic [23:0]      pal_rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_pixel
);
  logic take, use_direct, st_valid, st_fresh, st_bgr;
  rgb_t direct_rgb, st_rgb;

  assign in_ready  = !st_valid || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = st_valid;

  pms_decode #(.IDX_W(IDX_W)) u_dec (
    .take(take), .index(in_index), .direct(in_direct), .ctrl(in_ctrl),
    .use_direct(use_direct), .direct_rgb(direct_rgb),
    .rd_en(pal_rd_en), .rd_addr(pal_rd_addr)
  );

  pms_stage u_stg (
    .clk(clk), .rst_n(rst_n), .load(take), .pop(st_valid && out_ready),
    .use_direct(use_direct), .direct_rgb(direct_rgb), .bgr_in(in_bgr),
    .pal_data(pal_rd_data), .st_valid(st_valid), .st_fresh(st_fresh),
    .st_bgr(st_bgr), .st_rgb(st_rgb)
  );

  pms_pack u_pack (.rgb(st_rgb), .bgr(st_bgr), .pixel(out_pixel));
endmodule

// File: rtl/pms_chk.sv
module pms_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IDX_W-1:0] in_index,
  input logic [31:0]      in_ctrl,
  input logic             pal_rd_en,
  input logic [IDX_W-1:0] pal_rd_addr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_pixel
);
  a_r1_direct_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ctrl[31:24] == 8'h03) |-> !pal_rd_en);
  a_r2_read_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_en |-> (in_valid && in_ready && pal_rd_addr == in_index));
  a_r2_palette_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ctrl[31:24] != 8'h03) |-> pal_rd_en);
  a_r5_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pixel[31:24] == 8'h00);
  a_r6_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));
  a_r7_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);
endmodule

bind pix_mix_sel pms_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_index(in_index), .in_ctrl(in_ctrl), .pal_rd_en(pal_rd_en),
  .pal_rd_addr(pal_rd_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_pixel(out_pixel)
);

// File: tb/tb_pix_mix_sel.sv
module tb_pix_mix_sel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_bgr = 1'b0, out_ready = 1'b1;
  logic [7:0] in_index = '0;
  logic [31:0] in_direct = '0, in_ctrl = '0;
  logic in_ready, pal_rd_en, out_valid;
  logic [7:0] pal_rd_addr;
  logic [23:0] pal_rd_data;
  logic [31:0] out_pixel;

  int checks = 0, fails = 0, cyc = 0, stall_mode = 0;
  logic [31:0] expq[$];
  logic prev_hold = 1'b0;
  logic [31:0] prev_pix = '0;

  always #5 clk = ~clk;

  pix_mix_sel dut (.*);

  function automatic logic [23:0] table_rgb(input logic [7:0] i);
    return {i ^ 8'h5A, i + 8'd17, ~i};
  endfunction

  // colour table: one-cycle answer, junk otherwise
  always_ff @(posedge clk)
    pal_rd_data <= pal_rd_en ? table_rgb(pal_rd_addr) : 24'hC3A5E1;

  function automatic logic [31:0] expect_pix(input logic [7:0] idx,
      input logic [31:0] dw, input logic [31:0] cw, input logic bgr);
    logic [7:0] r, g, b;
    if (cw[31:24] == 8'h03) begin r = dw[7:0]; g = dw[15:8]; b = dw[23:16]; end
    else begin r = table_rgb(idx)[23:16]; g = table_rgb(idx)[15:8]; b = table_rgb(idx)[7:0]; end
    return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (stall_mode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      default: out_ready = (cyc % 3) == 0;
    endcase
  end

  // monitor
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_hold) check("R7 hold", out_pixel, prev_pix);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check("R6 extra pixel", 32'h1, 32'h0);
        else check("R3/R4/R5/R6 pixel", out_pixel, expq.pop_front());
      end
      prev_hold = out_valid && !out_ready;
      prev_pix  = out_pixel;
    end
  end

  task automatic send(input logic [7:0] idx, input logic [31:0] dw,
                      input logic [31:0] cw, input logic bgr);
    @(negedge clk);
    in_valid = 1'b1; in_index = idx; in_direct = dw; in_ctrl = cw; in_bgr = bgr;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    check("R1/R2 read enable", {31'h0, pal_rd_en}, {31'h0, cw[31:24] != 8'h03});
    if (cw[31:24] != 8'h03) check("R2 read address", {24'h0, pal_rd_addr}, {24'h0, idx});
    expq.push_back(expect_pix(idx, dw, cw, bgr));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    #12;
    check("R8 out_valid", {31'h0, out_valid}, 32'h0);
    check("R8 pal_rd_en", {31'h0, pal_rd_en}, 32'h0);
    check("R8 in_ready", {31'h0, in_ready}, 32'h1);
    @(negedge clk); rst_n = 1'b1;
    // R6 latency: pixel visible right after its accepting edge
    @(negedge clk);
    in_valid = 1'b1; in_index = 8'h10; in_ctrl = 32'h0; in_bgr = 1'b0;
    expq.push_back(expect_pix(8'h10, 32'h0, 32'h0, 1'b0));
    @(posedge clk); #1 in_valid = 1'b0;
    #1 check("R6 valid after edge", {31'h0, out_valid}, 32'h1);
    for (int m = 0; m < 3; m++) begin
      stall_mode = m;
      send(8'h01, 32'hFF_33_22_11, 32'h03_000000, 1'b0); // R1 R3 direct, top byte junk
      send(8'h02, 32'h00_33_22_11, 32'h03_FFFFFF, 1'b1); // R1 low ctrl bits ignored
      send(8'h7F, 32'h12345678, 32'h02_000000, 1'b0);    // R2 palette
      send(8'hFF, 32'h12345678, 32'h13_000000, 1'b1);    // R2
      send(8'h00, 32'h00ABCDEF, 32'h83_000003, 1'b0);    // R2 near-miss tag
      send(8'h80, 32'h00ABCDEF, 32'h00_000003, 1'b1);    // R2
      for (int k = 0; k < 20; k++)
        send(8'(k * 37 + m), {8'(k), 8'(k * 3), 8'(k * 5), 8'(k * 7)},
             (k % 3 == 0) ? 32'h03_000000 : {8'(k), 24'h0}, k[1]);
    end
    repeat (20) @(negedge clk);
    check("R6 all drained", expq.size(), 32'h0);
    finish_run();
  end
endmodule